// File: doc/BRIEF.md
# CSMA Transmitter Keying Controller

This block decides when a half-duplex packet radio may key its transmitter. A send queue reports that a frame is waiting. The block then runs a tick-driven p-persistent carrier-sense sequence. It raises the transmitter key, waits out the key-up delay, and issues a one-cycle frame-start strobe. That strobe also clears the transmit CRC. A byte transmitter reports the end of each frame, or an underrun, back to the block. Serialization, CRC generation and bit stuffing are handled elsewhere.

Every timed step uses one shared down-counter that moves once per system tick. The channel access parameters live in a small write-only register bank with reset defaults: key-up delay, persistence, slot length, tail length, wait length, key-up limit, minimum gap, idle hold and duplex mode. Duplex mode 0 listens to carrier and rolls a pseudo-random number for each decision. Mode 1 ignores the carrier. Mode 2 also keeps the transmitter keyed between bursts. A group-inhibit input marks the channel as busy in every mode.

Top module: `csma_key_ctrl`

## Requirements
- R1: Reset behaviour. After reset, `rts`, `tx_start` and `tx_abort` are low. The configuration holds these defaults, where a time in ms becomes floor(ms×TICK_HZ/1000) ticks:
  - key-up delay 360 ms, wait 500 ms, slot 160 ms, tail 30 ms
  - persistence 25
  - key-up limit 7 s, minimum gap 3 s, idle hold 120 s
  - duplex mode 0
- R2: Configuration writes. When `cfg_we` is high, `cfg_wdata` is written to the register that `cfg_addr` selects:
  - 0: key-up delay (ticks)
  - 1: persistence
  - 2: slot (ticks)
  - 3: tail (ticks)
  - 4: wait (ticks)
  - 5: key-up limit (seconds)
  - 6: minimum gap (seconds)
  - 7: idle hold (seconds)
  - 8: duplex mode (bits 1:0)

  A value in seconds is scaled by TICK_HZ.
- R3: Leaving idle. When `frame_pend` is high while the block is idle with no timer running, the block starts deferring. Its first channel decision comes on the wait-th tick. A timer loaded with zero, other than the key-up delay, expires on the next tick.
- R4: Persistence in mode 0. At each decision the 8-bit value R steps to (21·R + 53) mod 256, starting from 0 after reset. The channel counts as busy when `dcd` is high or persistence < the new R. A busy decision is followed by another decision one slot later.
- R5: Busy sources by mode. `grp_inhibit` makes the channel busy in every mode. In modes 1 and 2, `dcd` and persistence are ignored and R does not step.
- R6: Deferral budget. On entering deferral, a budget of idle-hold×TICK_HZ ticks is loaded. Each busy decision takes one slot from it. When less than one slot remains, the block keys up even on a busy channel.
- R7: Key-up delay. On key-up, `rts` rises, and the frame starts after key-up-delay ticks if a frame is still pending. With a key-up delay of zero, the block instead waits for a rising edge on `cts` and starts on the following tick.
- R8: Frame start. `tx_start` is a one-cycle strobe at each frame start. After `frame_done`, the next frame starts at once if `frame_pend` is high and the key-up limit, counted from key-up, has not run out. A key-up limit of zero means no limit.
- R9: Tail entry. Otherwise, after a frame, or after a key-up delay with nothing pending, the block enters the tail for tail ticks. An `underrun` while sending gives a one-cycle `tx_abort` strobe and enters the tail at once.
- R10: End of tail in modes 0 and 1. At the end of the tail, `rts` falls. If a frame is still pending, deferral restarts after a gap of minimum-gap×TICK_HZ ticks.
- R11: End of tail in mode 2. At the end of the tail, `rts` stays high. A pending frame starts after minimum-gap×TICK_HZ ticks. With nothing pending, `rts` falls after idle-hold×TICK_HZ ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle system tick, TICK_HZ per second |
| frame_pend | input | 1 | Send queue holds a frame |
| dcd | input | 1 | Carrier detected on the channel |
| cts | input | 1 | Clear to send from the radio |
| grp_inhibit | input | 1 | Another channel in the same group is busy |
| frame_done | input | 1 | Byte transmitter finished the current frame |
| underrun | input | 1 | Byte transmitter ran out of data mid-frame |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| rts | output | 1 | Transmitter key |
| tx_start | output | 1 | Frame start strobe, clears transmit CRC |
| tx_abort | output | 1 | Abort strobe after an underrun |

## Verification
The bench builds the block with TICK_HZ = 10, so a one-second setting becomes ten ticks. With that rate, the default wait, key-up delay and tail resolve to 5, 3 and 0 ticks. The deferral budget, the key-up limit, the minimum gap and the mode-2 idle hold therefore all expire within a few dozen ticks. The bench drives `tick` itself, which lets it count ticks exactly. It models the persistence sequence from seed zero to predict how many slots the block defers before it keys up.

// File: rtl/csma_key_pkg.sv
`timescale 1ns/1ps
// Shared types for the keying controller: the state encoding, the
// configuration record and the register select codes.
package csma_key_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEFER,
        ST_KEYWT,
        ST_ACTIVE,
        ST_FLUSH,
        ST_TAIL
    } key_state_t;

    typedef struct packed {
        logic [7:0] txdelay;
        logic [7:0] persist;
        logic [7:0] slot;
        logic [7:0] tail;
        logic [7:0] waitt;
        logic [7:0] maxkey;
        logic [7:0] mingap;
        logic [7:0] idle;
        logic [1:0] duplex;
    } key_cfg_t;

    localparam logic [3:0] A_TXDELAY = 4'd0;
    localparam logic [3:0] A_PERSIST = 4'd1;
    localparam logic [3:0] A_SLOT    = 4'd2;
    localparam logic [3:0] A_TAIL    = 4'd3;
    localparam logic [3:0] A_WAIT    = 4'd4;
    localparam logic [3:0] A_MAXKEY  = 4'd5;
    localparam logic [3:0] A_MINGAP  = 4'd6;
    localparam logic [3:0] A_IDLE    = 4'd7;
    localparam logic [3:0] A_DUPLEX  = 4'd8;

endpackage

// File: rtl/csma_key_cfg.sv
`timescale 1ns/1ps
// Configuration bank for the keying controller.
// Assumes: single write port, values take effect on the next cycle.
// Timing defaults are scaled to ticks from TICK_HZ.
module csma_key_cfg #(
    parameter int TICK_HZ = 100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [3:0]              cfg_addr,
    input  logic [7:0]              cfg_wdata,
    output csma_key_pkg::key_cfg_t  cfg
);
    import csma_key_pkg::*;

    localparam logic [7:0] D_TXD  = 8'(360 * TICK_HZ / 1000);
    localparam logic [7:0] D_SLOT = 8'(160 * TICK_HZ / 1000);
    localparam logic [7:0] D_TAIL = 8'(30 * TICK_HZ / 1000);
    localparam logic [7:0] D_WAIT = 8'(500 * TICK_HZ / 1000);

    // Register writes with reset to the default channel parameters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '{txdelay: D_TXD, persist: 8'd25, slot: D_SLOT,
                     tail: D_TAIL, waitt: D_WAIT, maxkey: 8'd7,
                     mingap: 8'd3, idle: 8'd120, duplex: 2'd0};
        end else if (cfg_we) begin
            case (cfg_addr)
                A_TXDELAY: cfg.txdelay <= cfg_wdata;
                A_PERSIST: cfg.persist <= cfg_wdata;
                A_SLOT:    cfg.slot    <= cfg_wdata;
                A_TAIL:    cfg.tail    <= cfg_wdata;
                A_WAIT:    cfg.waitt   <= cfg_wdata;
                A_MAXKEY:  cfg.maxkey  <= cfg_wdata;
                A_MINGAP:  cfg.mingap  <= cfg_wdata;
                A_IDLE:    cfg.idle    <= cfg_wdata;
                A_DUPLEX:  cfg.duplex  <= cfg_wdata[1:0];
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/csma_key_prng.sv
`timescale 1ns/1ps
// 8-bit linear congruential generator for the persistence roll.
// nxt is the value the generator takes on the next step; the caller
// compares against nxt in the cycle it steps.
module csma_key_prng (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    output logic [7:0] nxt
);
    logic [7:0] r;

    assign nxt = r * 8'd21 + 8'd53;

    // Advance the sequence on request; seed is zero after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    r <= '0;
        else if (step) r <= nxt;
    end

endmodule

// File: rtl/csma_key_timer.sv
`timescale 1ns/1ps
// Shared tick down-counter. A load wins over the tick decrement.
// fire marks the tick on which the count goes from one to zero;
// a count of zero is parked and never fires.
module csma_key_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic             cnt_zero,
    output logic             fire
);
    logic [CNT_W-1:0] cnt;

    assign cnt_zero = (cnt == '0);
    assign fire     = tick && (cnt == CNT_W'(1));

    // Load or count down once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (ld)               cnt <= ld_val;
        else if (tick && !cnt_zero) cnt <= cnt - CNT_W'(1);
    end

endmodule

// File: rtl/csma_key_ctrl.sv
`timescale 1ns/1ps
// Transmitter keying controller: p-persistent CSMA sequencing of the
// transmitter key around queued frames, with key-up delay, key-up limit,
// tail, minimum gap and idle hold timed on one shared tick counter.
// Assumes tick is a one-cycle pulse and frame_done/underrun are
// one-cycle pulses from the byte transmitter.
module csma_key_ctrl #(
    parameter int TICK_HZ = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       frame_pend,
    input  logic       dcd,
    input  logic       cts,
    input  logic       grp_inhibit,
    input  logic       frame_done,
    input  logic       underrun,
    input  logic       cfg_we,
    input  logic [3:0] cfg_addr,
    input  logic [7:0] cfg_wdata,
    output logic       rts,
    output logic       tx_start,
    output logic       tx_abort
);
    import csma_key_pkg::*;

    localparam int CNT_W = $clog2(255 * TICK_HZ + 1);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] HZ  = CNT_W'(TICK_HZ);

    key_cfg_t         cfg;
    key_state_t       st, st_n;
    logic             rts_n, start_c, abort_c, busy, step, cts_q, cts_rise;
    logic             ld, cnt_zero, fire;
    logic [CNT_W-1:0] ld_val, bud, bud_n;
    logic [CNT_W-1:0] txd_t, slot_t, tail_t, wait_t, maxkey_t, gap_t, idle_t;
    logic [7:0]       rnd_nxt;

    function automatic logic [CNT_W-1:0] nz(input logic [CNT_W-1:0] v);
        return (v == '0) ? ONE : v;
    endfunction

    csma_key_cfg #(.TICK_HZ(TICK_HZ)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg(cfg)
    );

    csma_key_prng u_prng (
        .clk(clk), .rst_n(rst_n), .step(step), .nxt(rnd_nxt)
    );

    csma_key_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ld(ld), .ld_val(ld_val),
        .cnt_zero(cnt_zero), .fire(fire)
    );

    assign txd_t    = CNT_W'(cfg.txdelay);
    assign slot_t   = CNT_W'(cfg.slot);
    assign tail_t   = CNT_W'(cfg.tail);
    assign wait_t   = CNT_W'(cfg.waitt);
    assign maxkey_t = CNT_W'(cfg.maxkey) * HZ;
    assign gap_t    = CNT_W'(cfg.mingap) * HZ;
    assign idle_t   = CNT_W'(cfg.idle) * HZ;
    assign cts_rise = cts && !cts_q;

    // Channel-busy verdict for the current deferral decision.
    always_comb begin
        busy = grp_inhibit ||
               ((cfg.duplex == 2'd0) && (dcd || (cfg.persist < rnd_nxt)));
    end

    // Next-state, timer load and strobe decisions.
    always_comb begin
        st_n    = st;
        rts_n   = rts;
        ld      = 1'b0;
        ld_val  = '0;
        bud_n   = bud;
        step    = 1'b0;
        start_c = 1'b0;
        abort_c = 1'b0;
        case (st)
            ST_IDLE: begin
                if (fire) begin
                    rts_n = 1'b0;
                end else if (cnt_zero && frame_pend) begin
                    st_n   = ST_DEFER;
                    ld     = 1'b1;
                    ld_val = nz(wait_t);
                    bud_n  = idle_t;
                end
            end
            ST_DEFER: begin
                if (fire) begin
                    step = (cfg.duplex == 2'd0);
                    if (busy && (bud >= slot_t)) begin
                        bud_n  = bud - slot_t;
                        ld     = 1'b1;
                        ld_val = nz(slot_t);
                    end else begin
                        rts_n  = 1'b1;
                        st_n   = ST_KEYWT;
                        ld     = 1'b1;
                        ld_val = txd_t;
                    end
                end
            end
            ST_KEYWT: begin
                if ((txd_t == '0) && cts_rise && cnt_zero) begin
                    ld     = 1'b1;
                    ld_val = ONE;
                end else if (fire) begin
                    ld = 1'b1;
                    if (frame_pend) begin
                        start_c = 1'b1;
                        st_n    = ST_ACTIVE;
                        ld_val  = maxkey_t;
                    end else begin
                        st_n   = ST_TAIL;
                        ld_val = nz(tail_t);
                    end
                end
            end
            ST_ACTIVE: begin
                if (underrun) begin
                    abort_c = 1'b1;
                    st_n    = ST_TAIL;
                    ld      = 1'b1;
                    ld_val  = nz(tail_t);
                end else if (frame_done) begin
                    st_n = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                if (frame_pend && (!cnt_zero || (maxkey_t == '0))) begin
                    start_c = 1'b1;
                    st_n    = ST_ACTIVE;
                end else begin
                    st_n   = ST_TAIL;
                    ld     = 1'b1;
                    ld_val = nz(tail_t);
                end
            end
            ST_TAIL: begin
                if (fire) begin
                    if (cfg.duplex != 2'd2) begin
                        rts_n = 1'b0;
                        st_n  = ST_IDLE;
                        if (frame_pend) begin
                            ld     = 1'b1;
                            ld_val = nz(gap_t);
                        end
                    end else if (frame_pend) begin
                        st_n   = ST_KEYWT;
                        ld     = 1'b1;
                        ld_val = nz(gap_t);
                    end else begin
                        st_n   = ST_IDLE;
                        ld     = 1'b1;
                        ld_val = nz(idle_t);
                    end
                end
            end
            default: begin
                st_n  = ST_IDLE;
                rts_n = 1'b0;
            end
        endcase
    end

    // State, key, budget, edge-detect and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            rts      <= 1'b0;
            bud      <= '0;
            cts_q    <= 1'b0;
            tx_start <= 1'b0;
            tx_abort <= 1'b0;
        end else begin
            st       <= st_n;
            rts      <= rts_n;
            bud      <= bud_n;
            cts_q    <= cts;
            tx_start <= start_c;
            tx_abort <= abort_c;
        end
    end

endmodule

// File: rtl/csma_key_chk.sv
`timescale 1ns/1ps
// Port-level protocol checks for the keying controller.
module csma_key_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic frame_pend,
    input logic rts,
    input logic tx_start,
    input logic tx_abort
);
    // R8: frames only start while keyed
    p_start_keyed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> rts);
    // R8: a start follows a cycle with a frame pending
    p_start_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> $past(frame_pend));
    // R8: starts are never back to back
    p_start_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);
    // R9: abort only while keyed, never with a start
    p_abort_keyed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> (rts && !tx_start));
    // R7: key-up is a timed decision
    p_rise_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rts) |-> $past(tick));
    // R10: key-down is a timed decision
    p_fall_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rts) |-> $past(tick));
endmodule

bind csma_key_ctrl csma_key_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .frame_pend(frame_pend),
    .rts(rts), .tx_start(tx_start), .tx_abort(tx_abort)
);

// File: tb/csma_key_ctrl_tb_top.sv
`timescale 1ns/1ps
module csma_key_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, frame_pend = 1'b0, dcd = 1'b0, cts = 1'b0;
    logic       grp_inhibit = 1'b0, frame_done = 1'b0, underrun = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       rts, tx_start, tx_abort;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    csma_key_ctrl #(.TICK_HZ(10)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .frame_pend(frame_pend),
        .dcd(dcd), .cts(cts), .grp_inhibit(grp_inhibit),
        .frame_done(frame_done), .underrun(underrun), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rts(rts),
        .tx_start(tx_start), .tx_abort(tx_abort)
    );

    typedef struct packed {
        logic [7:0] mode, persist, txd, wt, tl, e_key, e_start, e_drop;
    } vec_t;

    // mode, persist, txdelay, wait, tail -> ticks to key, to start, to drop
    localparam vec_t VECS [5] = '{
        '{8'd1, 8'd25,  8'd4, 8'd2, 8'd2, 8'd2, 8'd4, 8'd2},
        '{8'd1, 8'd25,  8'd1, 8'd1, 8'd0, 8'd1, 8'd1, 8'd1},
        '{8'd2, 8'd25,  8'd3, 8'd5, 8'd2, 8'd5, 8'd3, 8'd12},
        '{8'd0, 8'd255, 8'd2, 8'd3, 8'd1, 8'd3, 8'd2, 8'd1},
        '{8'd1, 8'd25,  8'd7, 8'd3, 8'd3, 8'd3, 8'd7, 8'd3}
    };

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 0; frame_pend = 0; dcd = 0; cts = 0;
        grp_inhibit = 0; frame_done = 0; underrun = 0; cfg_we = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic tick1();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic ticks_to_rts(input logic lvl, output int n);
        n = 0;
        while (rts != lvl && n < 3000) begin
            tick1();
            n++;
        end
    endtask

    task automatic ticks_to_start(output int n, output bit dropped);
        n = 0; dropped = 0;
        while (n < 3000) begin
            tick1();
            n++;
            if (!rts) dropped = 1;
            if (tx_start) break;
        end
    endtask

    task automatic pulse_done();
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #750000;
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog act=1 exp=0");
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int n;
        bit dr;
        int exp_n;
        logic [7:0] r;

        // R1: reset state
        apply_reset();
        chk("R1 rts", int'(rts), 0);
        chk("R1 tx_start", int'(tx_start), 0);
        chk("R1 tx_abort", int'(tx_abort), 0);

        // Table walk: R2 writes, R3 wait, R7 delay, R9/R10/R11 tail
        wr(4'd7, 8'd1);
        foreach (VECS[i]) begin
            wr(4'd8, VECS[i].mode);
            wr(4'd1, VECS[i].persist);
            wr(4'd0, VECS[i].txd);
            wr(4'd4, VECS[i].wt);
            wr(4'd3, VECS[i].tl);
            frame_pend = 1'b1;
            ticks_to_rts(1'b1, n);
            chk($sformatf("R3 vec%0d key ticks", i), n, int'(VECS[i].e_key));
            ticks_to_start(n, dr);
            chk($sformatf("R7 vec%0d start ticks", i), n, int'(VECS[i].e_start));
            frame_pend = 1'b0;
            pulse_done();
            ticks_to_rts(1'b0, n);
            chk($sformatf("R9 vec%0d drop ticks", i), n, int'(VECS[i].e_drop));
        end

        // R1: defaults (wait 5, key-up delay 3, tail 0 -> 1 tick) in mode 1
        apply_reset();
        wr(4'd8, 8'd1);
        frame_pend = 1'b1;
        ticks_to_rts(1'b1, n);
        chk("R1 default wait", n, 5);
        ticks_to_start(n, dr);
        chk("R1 default txdelay", n, 3);
        frame_pend = 1'b0;
        pulse_done();
        ticks_to_rts(1'b0, n);
        chk("R1 default tail", n, 1);

        // R4: persistence 25 with generator model from seed 0
        apply_reset();
        r = 8'd0; exp_n = 5;
        for (int k = 0; k < 300; k++) begin
            r = r * 8'd21 + 8'd53;
            if (r <= 8'd25) break;
            exp_n++;
        end
        frame_pend = 1'b1;
        ticks_to_rts(1'b1, n);
        chk("R4 persistence ticks", n, exp_n);

        // R6: carrier held, budget 10 ticks, slot 2 -> 5 deferrals
        apply_reset();
        wr(4'd1, 8'd255); wr(4'd2, 8'd2); wr(4'd7, 8'd1); wr(4'd4, 8'd1);
        dcd = 1'b1;
        frame_pend = 1'b1;
        ticks_to_rts(1'b1, n);
        chk("R6 budget key-up ticks", n, 11);

        // R5: carrier ignored in mode 1
        apply_reset();
        wr(4'd8, 8'd1); wr(4'd4, 8'd1);
        dcd = 1'b1;
        frame_pend = 1'b1;
        ticks_to_rts(1'b1, n);
        chk("R5 dcd ignored mode1", n, 1);

        // R5: group inhibit busy in mode 1, slot 3, budget 10 -> 3 deferrals
        apply_reset();
        wr(4'd8, 8'd1); wr(4'd4, 8'd1); wr(4'd2, 8'd3); wr(4'd7, 8'd1);
        grp_inhibit = 1'b1;
        frame_pend = 1'b1;
        ticks_to_rts(1'b1, n);
        chk("R5 group inhibit ticks", n, 10);

        // R7: zero key-up delay waits for a cts rising edge
        apply_reset();
        wr(4'd8, 8'd1); wr(4'd4, 8'd1); wr(4'd0, 8'd0);
        frame_pend = 1'b1;
        ticks_to_rts(1'b1, n);
        n = 0;
        for (int k = 0; k < 4; k++) begin
            tick1();
            if (tx_start) n++;
        end
        chk("R7 no start without cts", n, 0);
        cts = 1'b1;
        @(negedge clk);
        tick1();
        chk("R7 start after cts edge", int'(tx_start), 1);

        // R8/R9/R10: key-up limit 10 ticks, tail 1, gap 10
        apply_reset();
        wr(4'd8, 8'd1); wr(4'd5, 8'd1); wr(4'd0, 8'd1); wr(4'd4, 8'd1);
        wr(4'd3, 8'd1); wr(4'd6, 8'd1);
        frame_pend = 1'b1;
        ticks_to_rts(1'b1, n);
        ticks_to_start(n, dr);
        pulse_done();
        chk("R8 back-to-back start", int'(tx_start), 1);
        repeat (10) tick1();
        pulse_done();
        chk("R8 limit blocks start", int'(tx_start), 0);
        ticks_to_rts(1'b0, n);
        chk("R9 tail after limit", n, 1);
        ticks_to_rts(1'b1, n);
        chk("R10 gap then rekey", n, 11);

        // R9/R11: underrun, then mode-2 hold with and without pending frames
        apply_reset();
        wr(4'd8, 8'd2); wr(4'd0, 8'd1); wr(4'd4, 8'd1); wr(4'd3, 8'd2);
        wr(4'd6, 8'd1); wr(4'd7, 8'd1);
        frame_pend = 1'b1;
        ticks_to_rts(1'b1, n);
        ticks_to_start(n, dr);
        underrun = 1'b1;
        @(negedge clk);
        underrun = 1'b0;
        chk("R9 abort strobe", int'(tx_abort), 1);
        ticks_to_start(n, dr);
        chk("R11 restart after tail+gap", n, 12);
        chk("R11 key held", int'(dr), 0);
        frame_pend = 1'b0;
        pulse_done();
        ticks_to_rts(1'b0, n);
        chk("R11 idle hold drop", n, 12);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule